// File: doc/BRIEF.md
# Serial GPIO expander controller

This block adds up to 128 general-purpose inputs and 128 general-purpose outputs to a chip while using only four pins: a serial clock, a load strobe, a serial data output and a serial data input. Outside the chip, a chain of shift registers converts the serial stream to parallel outputs, and parallel-load registers return the input levels. The GPIOs are grouped into 32 ports. Each port carries 1 to 4 bits, and one setting gives that count for all ports. A 32-bit port-enable mask chooses the ports that appear in the stream. A disabled port is left out completely, so a lightly populated board needs a shorter frame.

Software writes the output values, the per-GPIO polarity, the mask and a control word through a plain register port, and reads back the captured inputs. When enabled, the controller sends frames back to back. A frame first shifts every enabled bit. It then holds the load strobe for one serial-clock period, which latches the outputs and takes a new input snapshot in the external registers. The serial clock is made by dividing the reference clock. Configuration is copied into the controller only at the start of a frame.

Top module: `serial_gpio_ctl`

## Requirements
- R1: Register map, 4-bit word addresses, 32-bit data. Address 0 is control: bit 0 enable, bits 2:1 bits-per-port minus one, bits 31:16 divider. Address 1 is the port-enable mask, with bit p for port p. Addresses 2-5 hold output values, 6-9 hold polarity, and 10-13 hold the captured inputs (read only). Word w holds GPIO 32w+j in bit j, and GPIO index = 4*port + bit.
- R2: After reset, control reads 0x00070006 (disabled, 4 bits per port, divider 7), the mask reads 0xFFFFFFFF, outputs, polarity and inputs read 0, and all three output pins are low.
- R3: A frame visits ports in ascending order and, within a port, bits 0 up to bits-per-port minus 1. Disabled ports add no clock pulses, so a frame has exactly (enabled ports) x (bits per port) serial-clock rising edges before the strobe.
- R4: The data-out pin carries the output value XOR the polarity bit of the GPIO being shifted. It changes only while the serial clock is low.
- R5: The data-in pin is sampled at each serial-clock rising edge. The captured value, XOR the polarity bit of that GPIO, becomes that GPIO's input bit.
- R6: Each serial-clock phase lasts divider+1 reference cycles, so one bit takes 2*(divider+1) cycles.
- R7: After the last bit of a frame, the load strobe is high for 2*(divider+1) reference cycles, and the serial clock stays low while the strobe is high.
- R8: The readable input words change only at the end of a load strobe. A read in the middle of a frame returns the previous frame's values. GPIOs that are not in the stream keep their last value.
- R9: Changes to the mask, the bits-per-port setting and the divider take effect at the next frame start. A write that lands on the very cycle a frame restarts applies only from the frame after that one.
- R10: While enabled with an all-zero mask, the serial clock and strobe stay low and the input words hold their values. Frames resume once a non-zero mask is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write word address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 4 | Register read word address |
| rdData | output | 32 | Register read data (combinational) |
| serIn | input | 1 | Serial data from the external chain |
| serClk | output | 1 | Serial shift clock |
| serLoad | output | 1 | Load strobe to the external registers |
| serOut | output | 1 | Serial data to the external chain |

## Verification
The hardest collision is a host write to the mask landing on the same reference-clock edge where the controller finishes a load strobe and copies the live configuration for the next frame. The bench counts cycles from the strobe's rising edge and places one mask write a cycle before that restart edge and one exactly on it. It then judges the result from the number of serial-clock pulses in each of the following frames: the earlier write must shorten the very next frame, and the on-edge write only the one after. A second collision, the input commit against a host read, is covered by reading the input words while a new frame is already sampling changed data-in values.

// File: rtl/sgx_pkg.sv
package sgx_pkg;
  localparam int NPORT  = 32;
  localparam int MAXBPP = 4;
  localparam int NGPIO  = NPORT * MAXBPP;
  localparam int PORTW  = $clog2(NPORT);
  localparam int BITW   = $clog2(MAXBPP);
  localparam int IDXW   = PORTW + BITW;
  localparam int NWORD  = NGPIO / 32;
  localparam int DIVW   = 16;
  localparam int AW     = 4;

  localparam logic [AW-1:0] A_CTRL = 4'd0;
  localparam logic [AW-1:0] A_MASK = 4'd1;
  localparam logic [AW-1:0] A_OUT0 = 4'd2;
  localparam logic [AW-1:0] A_POL0 = 4'd6;
  localparam logic [AW-1:0] A_IN0  = 4'd10;

  typedef struct packed {
    logic            en;
    logic [BITW-1:0] bppm1;
    logic [DIVW-1:0] div;
  } cfg_t;

  typedef struct packed {
    logic            drive;
    logic            sample;
    logic            commit;
    logic [IDXW-1:0] idx;
  } strobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_LOAD} sgx_state_e;
endpackage

// File: rtl/sgx_datapath.sv
module sgx_datapath
  import sgx_pkg::*;
#(
  parameter int DEFAULT_DIV = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [31:0]      wrData,
  input  logic [AW-1:0]    rdAddr,
  output logic [31:0]      rdData,
  input  strobe_t          stb,
  input  logic             serIn,
  output logic             serOut,
  output cfg_t             cfgOut,
  output logic [NPORT-1:0] maskOut,
  output logic [NGPIO-1:0] inAll
);
  cfg_t             cfgReg;
  logic [NPORT-1:0] maskReg;
  logic [NGPIO-1:0] outReg;
  logic [NGPIO-1:0] polReg;
  logic [NGPIO-1:0] capReg;
  logic [NGPIO-1:0] inReg;
  logic             sdoReg;

  // host-visible register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg.en    <= 1'b0;
      cfgReg.bppm1 <= '1;
      cfgReg.div   <= DIVW'(DEFAULT_DIV);
      maskReg      <= '1;
      outReg       <= '0;
      polReg       <= '0;
    end else if (wrEn) begin
      if (wrAddr == A_CTRL) begin
        cfgReg.en    <= wrData[0];
        cfgReg.bppm1 <= wrData[BITW:1];
        cfgReg.div   <= wrData[31:32-DIVW];
      end
      if (wrAddr == A_MASK) maskReg <= wrData[NPORT-1:0];
      for (int w = 0; w < NWORD; w++) begin
        if (wrAddr == A_OUT0 + AW'(w)) outReg[w*32 +: 32] <= wrData;
        if (wrAddr == A_POL0 + AW'(w)) polReg[w*32 +: 32] <= wrData;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == A_CTRL) begin
      rdData[0]           = cfgReg.en;
      rdData[BITW:1]      = cfgReg.bppm1;
      rdData[31:32-DIVW]  = cfgReg.div;
    end
    if (rdAddr == A_MASK) rdData[NPORT-1:0] = maskReg;
    for (int w = 0; w < NWORD; w++) begin
      if (rdAddr == A_OUT0 + AW'(w)) rdData = outReg[w*32 +: 32];
      if (rdAddr == A_POL0 + AW'(w)) rdData = polReg[w*32 +: 32];
      if (rdAddr == A_IN0  + AW'(w)) rdData = inReg[w*32 +: 32];
    end
  end

  // serial data path: drive, sample, frame commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdoReg <= 1'b0;
      capReg <= '0;
      inReg  <= '0;
    end else begin
      if (stb.drive)  sdoReg <= outReg[stb.idx] ^ polReg[stb.idx];
      if (stb.sample) capReg[stb.idx] <= serIn ^ polReg[stb.idx];
      if (stb.commit) inReg <= capReg;
    end
  end

  assign serOut  = sdoReg;
  assign cfgOut  = cfgReg;
  assign maskOut = maskReg;
  assign inAll   = inReg;
endmodule

// File: rtl/sgx_control.sv
module sgx_control
  import sgx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cfg_t             cfgIn,
  input  logic [NPORT-1:0] maskIn,
  output strobe_t          stbOut,
  output logic             serClk,
  output logic             serLoad
);
  sgx_state_e       st, stNxt;
  logic [DIVW-1:0]  cnt, cntNxt, divS, divNxt;
  logic [NPORT-1:0] maskS, maskNxt;
  logic [BITW-1:0]  bppS, bppNxt, bitCur, bitNxt;
  logic [PORTW-1:0] portCur, portNxt, firstPort, nextPort;
  logic             phase, phaseNxt, nextFound, halfEnd, startOk, startNow;
  logic             sclkQ, loadQ;

  assign startOk = cfgIn.en && (|maskIn);
  assign halfEnd = (cnt == divS);

  // lowest enabled port in the live mask
  always_comb begin
    firstPort = '0;
    for (int i = NPORT-1; i >= 0; i--)
      if (maskIn[i]) firstPort = PORTW'(i);
  end

  // lowest enabled port above the current one in the frame's mask
  always_comb begin
    nextPort  = '0;
    nextFound = 1'b0;
    for (int i = NPORT-1; i >= 0; i--)
      if (maskS[i] && (i > int'(portCur))) begin
        nextPort  = PORTW'(i);
        nextFound = 1'b1;
      end
  end

  always_comb begin
    stNxt = st; cntNxt = cnt; phaseNxt = phase;
    portNxt = portCur; bitNxt = bitCur;
    divNxt = divS; maskNxt = maskS; bppNxt = bppS;
    stbOut = '0;
    startNow = 1'b0;
    case (st)
      ST_IDLE: startNow = startOk;
      ST_SHIFT, ST_LOAD: begin
        if (!halfEnd) begin
          cntNxt = cnt + DIVW'(1);
        end else begin
          cntNxt   = '0;
          phaseNxt = ~phase;
          if (!phase) begin
            if (st == ST_SHIFT) begin
              stbOut.sample = 1'b1;
              stbOut.idx    = {portCur, bitCur};
            end
          end else if (st == ST_LOAD) begin
            stbOut.commit = 1'b1;
            stNxt         = ST_IDLE;
            startNow      = startOk;
          end else if (bitCur != bppS) begin
            bitNxt       = bitCur + BITW'(1);
            stbOut.drive = 1'b1;
            stbOut.idx   = {portCur, bitCur + BITW'(1)};
          end else if (nextFound) begin
            portNxt      = nextPort;
            bitNxt       = '0;
            stbOut.drive = 1'b1;
            stbOut.idx   = {nextPort, {BITW{1'b0}}};
          end else begin
            stNxt = ST_LOAD;
          end
        end
      end
      default: stNxt = ST_IDLE;
    endcase
    if (startNow) begin
      stNxt        = ST_SHIFT;
      cntNxt       = '0;
      phaseNxt     = 1'b0;
      divNxt       = cfgIn.div;
      maskNxt      = maskIn;
      bppNxt       = cfgIn.bppm1;
      portNxt      = firstPort;
      bitNxt       = '0;
      stbOut.drive = 1'b1;
      stbOut.idx   = {firstPort, {BITW{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= ST_IDLE; cnt <= '0; phase <= 1'b0;
      divS <= '0; maskS <= '0; bppS <= '0;
      portCur <= '0; bitCur <= '0;
      sclkQ <= 1'b0; loadQ <= 1'b0;
    end else begin
      st <= stNxt; cnt <= cntNxt; phase <= phaseNxt;
      divS <= divNxt; maskS <= maskNxt; bppS <= bppNxt;
      portCur <= portNxt; bitCur <= bitNxt;
      sclkQ <= (stNxt == ST_SHIFT) && phaseNxt;
      loadQ <= (stNxt == ST_LOAD);
    end
  end

  assign serClk  = sclkQ;
  assign serLoad = loadQ;
endmodule

// File: rtl/serial_gpio_ctl.sv
module serial_gpio_ctl
  import sgx_pkg::*;
#(
  parameter int DEFAULT_DIV = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [3:0]  rdAddr,
  output logic [31:0] rdData,
  input  logic        serIn,
  output logic        serClk,
  output logic        serLoad,
  output logic        serOut
);
  strobe_t          stb;
  cfg_t             cfg;
  logic [NPORT-1:0] portMask;
  logic [NGPIO-1:0] inAll;

  sgx_datapath #(.DEFAULT_DIV(DEFAULT_DIV)) u_dp (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .stb(stb), .serIn(serIn), .serOut(serOut),
    .cfgOut(cfg), .maskOut(portMask), .inAll(inAll)
  );

  sgx_control u_ctl (
    .clk(clk), .rstN(rstN),
    .cfgIn(cfg), .maskIn(portMask),
    .stbOut(stb), .serClk(serClk), .serLoad(serLoad)
  );
endmodule

// File: rtl/sgx_checks.sv
module sgx_checks
  import sgx_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             serClk,
  input logic             serLoad,
  input logic             serOut,
  input logic [NGPIO-1:0] inAll
);
  // R4
  sdo_stable_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (serClk && $past(serClk)) |-> $stable(serOut));

  // R7
  load_clk_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    serLoad |-> !serClk);

  // R7
  load_min_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serLoad) |=> serLoad);

  // R8
  in_commit_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(inAll) |-> $fell(serLoad));

  // R3
  load_after_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serLoad) |-> $past(serClk));
endmodule

bind serial_gpio_ctl sgx_checks u_chk (
  .clk(clk), .rstN(rstN), .serClk(serClk), .serLoad(serLoad),
  .serOut(serOut), .inAll(inAll)
);

// File: tb/sim_serial_gpio_ctl.sv
`timescale 1ns/1ps
module sim_serial_gpio_ctl;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [3:0]  wrAddr, rdAddr;
  logic [31:0] wrData, rdData;
  logic        serIn, serClk, serLoad, serOut;

  always #2.5 clk = ~clk;

  serial_gpio_ctl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .serIn(serIn),
    .serClk(serClk), .serLoad(serLoad), .serOut(serOut)
  );

  int nChecks = 0, nFail = 0, cyc = 0;
  int riseCnt = 0, lastLen = 0, riseCyc0 = 0, curGap = 0, lastGap = 0;
  int loadStart = 0, lastLoadW = 0, totRise = 0, totLoad = 0;
  int expN = 0;
  int expIdx [128];
  bit done = 0;
  logic [127:0] sdiPat = '0, seenBits = '0, lastBits = '0, expIn = '0;

  logic [31:0] cfgMask [8] = '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000005, 32'h80000001,
                               32'h0000F00F, 32'hAAAAAAAA, 32'h40000000, 32'h00000001};
  int cfgBpp [8] = '{4, 1, 2, 3, 4, 2, 4, 2};
  int cfgDiv [8] = '{0, 1, 2, 0, 1, 0, 2, 0};

  always @(posedge clk) cyc++;

  // external shift-chain model: input bit k of the frame is sdiPat[k]
  assign serIn = (riseCnt < 128) ? sdiPat[riseCnt] : 1'b0;

  always @(posedge serClk) begin
    if (riseCnt < 128) seenBits[riseCnt] = serOut;
    if (riseCnt == 0) riseCyc0 = cyc;
    else if (riseCnt == 1) curGap = cyc - riseCyc0;
    riseCnt++;
    totRise++;
  end
  always @(posedge serLoad) begin
    lastLen = riseCnt; lastBits = seenBits; lastGap = curGap;
    riseCnt = 0; loadStart = cyc; totLoad++;
  end
  always @(negedge serLoad) lastLoadW = cyc - loadStart;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic regRd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rdAddr = a; #1 d = rdData;
  endtask

  task automatic readIn(output logic [127:0] v);
    logic [31:0] d;
    for (int w = 0; w < 4; w++) begin
      regRd(4'(10 + w), d);
      v[w*32 +: 32] = d;
    end
  endtask

  function automatic logic [31:0] ctrlWord(input bit en, input int bpp, input int dv);
    return {dv[15:0], 13'b0, 2'(bpp - 1), en};
  endfunction

  task automatic buildList(input logic [31:0] m, input int bpp);
    expN = 0;
    for (int p = 0; p < 32; p++)
      if (m[p]) for (int b = 0; b < bpp; b++) begin expIdx[expN] = p*4 + b; expN++; end
  endtask

  task automatic quiesce();
    regWr(4'd0, ctrlWord(1'b0, 4, 0));
    repeat (1000) @(posedge clk);
  endtask

  task automatic runCfg(input int i);
    logic [127:0] outv, polv, sdiv, rd, expBits;
    int bad;
    for (int w = 0; w < 4; w++) begin
      outv[w*32 +: 32] = 32'h9E3779B9 * (i*4 + w + 1);
      polv[w*32 +: 32] = 32'h85EBCA6B * (i*4 + w + 7);
      sdiv[w*32 +: 32] = 32'hC2B2AE35 * (i*4 + w + 11);
    end
    quiesce();
    regWr(4'd1, cfgMask[i]);
    for (int w = 0; w < 4; w++) begin
      regWr(4'(2 + w), outv[w*32 +: 32]);
      regWr(4'(6 + w), polv[w*32 +: 32]);
    end
    sdiPat = sdiv;
    buildList(cfgMask[i], cfgBpp[i]);
    regWr(4'd0, ctrlWord(1'b1, cfgBpp[i], cfgDiv[i]));
    @(posedge serLoad); #1;
    chk(lastLen == expN, "R3 frame length", 128'(lastLen), 128'(expN));
    bad = 0; expBits = '0;
    for (int k = 0; k < expN; k++) begin
      expBits[k] = outv[expIdx[k]] ^ polv[expIdx[k]];
      if (lastBits[k] !== expBits[k]) bad++;
    end
    chk(bad == 0, "R4 data-out sequence", lastBits, expBits);
    chk(lastGap == 2*(cfgDiv[i]+1), "R6 bit period", 128'(lastGap), 128'(2*(cfgDiv[i]+1)));
    @(negedge serLoad); #1;
    sdiPat = ~sdiv;
    chk(lastLoadW == 2*(cfgDiv[i]+1), "R7 strobe width", 128'(lastLoadW), 128'(2*(cfgDiv[i]+1)));
    for (int k = 0; k < expN; k++) expIn[expIdx[k]] = sdiv[k] ^ polv[expIdx[k]];
    readIn(rd);
    chk(rd == expIn, "R5 R8 inputs after frame, read mid next frame", rd, expIn);
    @(posedge serLoad); @(negedge serLoad); #1;
    for (int k = 0; k < expN; k++) expIn[expIdx[k]] = ~sdiv[k] ^ polv[expIdx[k]];
    readIn(rd);
    chk(rd == expIn, "R5 inputs after second frame", rd, expIn);
  endtask

  task automatic timedMaskWr(input int nNeg, input logic [31:0] m);
    repeat (nNeg) @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd1; wrData = m;
    @(negedge clk); wrEn = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    logic [127:0] snap, rd;
    int r0, l0;
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; rdAddr = '0;
    repeat (5) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    chk(serClk == 0 && serLoad == 0 && serOut == 0, "R2 pins idle after reset",
        128'({serClk, serLoad, serOut}), 128'(0));
    regRd(4'd0, d); chk(d == 32'h00070006, "R2 control reset", 128'(d), 128'h00070006);
    regRd(4'd1, d); chk(d == 32'hFFFFFFFF, "R2 mask reset", 128'(d), 128'hFFFFFFFF);
    regRd(4'd10, d); chk(d == 0, "R2 input reset", 128'(d), 128'(0));
    regWr(4'd5, 32'h12345678); regRd(4'd5, d);
    chk(d == 32'h12345678, "R1 output word 3 readback", 128'(d), 128'h12345678);
    regWr(4'd7, 32'hCAFE0001); regRd(4'd7, d);
    chk(d == 32'hCAFE0001, "R1 polarity word 1 readback", 128'(d), 128'hCAFE0001);

    for (int i = 0; i < 8; i++) runCfg(i);

    // R9: mask writes against the frame-restart edge (divider 1, 2 bits per port)
    quiesce();
    regWr(4'd1, 32'h0000000F);
    regWr(4'd0, ctrlWord(1'b1, 2, 1));
    @(posedge serLoad); #1;
    timedMaskWr(3, 32'h00000003);
    @(posedge serLoad); #1;
    chk(lastLen == 4, "R9 write before restart edge applies next frame", 128'(lastLen), 128'(4));
    timedMaskWr(4, 32'h00010101);
    @(posedge serLoad); #1;
    chk(lastLen == 4, "R9 write on restart edge keeps old mask", 128'(lastLen), 128'(4));
    @(posedge serLoad); #1;
    chk(lastLen == 6, "R9 write on restart edge applies one frame later", 128'(lastLen), 128'(6));
    @(negedge serLoad);
    timedMaskWr(2, 32'h80000000);
    @(posedge serLoad); #1;
    chk(lastLen == 6, "R9 mid-frame write leaves frame length", 128'(lastLen), 128'(6));
    @(posedge serLoad); #1;
    chk(lastLen == 2, "R9 mid-frame write used by next frame", 128'(lastLen), 128'(2));

    // R10: empty mask
    quiesce();
    readIn(snap);
    regWr(4'd1, 32'h0);
    regWr(4'd0, ctrlWord(1'b1, 4, 0));
    r0 = totRise; l0 = totLoad;
    repeat (300) @(posedge clk);
    #1;
    chk(totRise == r0 && totLoad == l0 && serClk == 0 && serLoad == 0,
        "R10 no activity with empty mask", 128'(totRise - r0 + totLoad - l0), 128'(0));
    readIn(rd);
    chk(rd == snap, "R10 inputs held with empty mask", rd, snap);
    regWr(4'd1, 32'h00000002);
    repeat (200) @(posedge clk);
    #1;
    chk(totLoad > l0, "R10 frames resume after non-zero mask", 128'(totLoad - l0), 128'(1));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end
endmodule